// File: doc/BRIEF.md
# Burst Master Address Sequencer

This block drives the address and control half of a pipelined bus master. User logic offers a transfer through a small request port: valid, direction, start address, burst code, transfer size and, for open-ended incrementing bursts, a beat count. The sequencer turns that request into a train of address phases on `haddr`, `htrans`, `hburst`, `hsize` and `hwrite`. It computes each following beat address itself, including the wrap inside an aligned block for wrapping bursts.

Two strobes pace the user side. `addr_req` says that a request presented now will be placed on the bus at the next clock edge. `wdata_req` says that the write address phase on the bus is completing in this cycle, so its data belongs on the write data bus in the next cycle. The user may stall a burst with `req_pause`, which produces BUSY cycles. A low `hready` freezes every registered output.

Top module: `burst_addr_seq`

## Requirements
- R1: After reset `htrans` is IDLE (2'b00), `haddr` is zero, and `hburst`, `hsize` and `hwrite` are zero.
- R2: `addr_req` is high exactly when `hready` and `hgrant` are high and no burst beats remain to be issued. When `addr_req` and `req_valid` are high together, the next cycle shows the request on the bus as NONSEQ (2'b10), with its burst code, size and direction.
- R3: `htrans` uses 00 IDLE, 01 BUSY, 10 NONSEQ and 11 SEQ. A burst issues one NONSEQ beat, then only SEQ beats. The beat count is set by `req_burst`: 000 gives 1 beat, 001 gives `req_len`+1 beats, 011 and 010 give 4, 101 and 100 give 8, and 111 and 110 give 16.
- R4: In single and incrementing bursts (000, 001, 011, 101, 111), each beat address is the previous one plus 2^`hsize` bytes.
- R5: In wrapping bursts (010, 100, 110), addresses step by 2^`hsize` inside an aligned block of beats × 2^`hsize` bytes. The bits above that block stay fixed, and the low bits wrap to the block start.
- R6: While beats remain and `hready` is high, `req_pause` makes the next cycle BUSY. That cycle shows the address of the next beat, and no beat is consumed. The following SEQ beat carries that same address.
- R7: While `hready` is low, `haddr`, `htrans`, `hburst`, `hsize` and `hwrite` keep their values, and no request is accepted.
- R8: `wdata_req` is high exactly when `hready` is high, `hwrite` is high and `htrans` is NONSEQ or SEQ.
- R9: The NONSEQ address is `req_addr` with its low `req_size` bits cleared, so it is aligned to the transfer size.
- R10: When no beats remain and `hready` is high, the next cycle is IDLE if `hgrant` is high without `req_valid`, or if `hgrant` is low.
- R11: `req_pause` has no effect when no beats remain. A request is still accepted, and an idle bus stays IDLE.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hgrant | input | 1 | Bus granted to this master |
| hready | input | 1 | Current transfer completes this cycle |
| req_valid | input | 1 | User offers a request |
| req_write | input | 1 | Request direction, 1 for write |
| req_addr | input | AW | Request start address |
| req_burst | input | 3 | Request burst code |
| req_size | input | 3 | log2 of bytes per beat |
| req_len | input | LW | Beats minus one for code 001 |
| req_pause | input | 1 | Insert a BUSY cycle inside a burst |
| haddr | output | AW | Bus address |
| htrans | output | 2 | Transfer type |
| hburst | output | 3 | Burst code on the bus |
| hsize | output | 3 | Transfer size on the bus |
| hwrite | output | 1 | Transfer direction on the bus |
| addr_req | output | 1 | Request will be taken at the next edge |
| wdata_req | output | 1 | Drive write data in the next cycle |

## Verification
The bench targets four cases. The first is the wrap point of each wrapping length, where a design that adds without masking would run past the block boundary. The second is a BUSY cycle: a design that advances the address twice would skip a beat, and one that does not advance at all would show a stale address. The third is a wait state that arrives during a pause or on the last beat: a design that updates anyway loses or repeats a beat, or takes a request early. The last is a misaligned start address and the open-ended incrementing length, where wrong masking or an off-by-one count would show up as a bad first address or as one beat too many or too few.

// File: rtl/burst_addr_seq.sv
module burst_addr_seq #(
  parameter int AW = 32,
  parameter int LW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hgrant,
  input  logic          hready,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [2:0]    req_burst,
  input  logic [2:0]    req_size,
  input  logic [LW-1:0] req_len,
  input  logic          req_pause,
  output logic [AW-1:0] haddr,
  output logic [1:0]    htrans,
  output logic [2:0]    hburst,
  output logic [2:0]    hsize,
  output logic          hwrite,
  output logic          addr_req,
  output logic          wdata_req
);
  localparam int CW = (LW > 4) ? LW : 4;
  localparam logic [1:0] T_IDLE = 2'b00, T_BUSY = 2'b01, T_NSEQ = 2'b10, T_SEQ = 2'b11;

  logic [CW-1:0] rem;
  logic [AW-1:0] adv_addr, load_addr;
  logic [CW-1:0] load_rem;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] a, input logic [2:0] b,
                                         input logic [2:0] s);
    logic [AW-1:0] inc, span;
    inc  = AW'(1) << s;
    span = inc << ({1'b0, b[2:1]} + 3'd1);
    if (b[0] == 1'b0 && b[2:1] != 2'b00)
      return (a & ~(span - AW'(1))) | ((a + inc) & (span - AW'(1)));
    return a + inc;
  endfunction

  assign addr_req  = hready & hgrant & (rem == '0);
  assign wdata_req = hready & hwrite & htrans[1];
  assign adv_addr  = (htrans == T_BUSY) ? haddr : bump(haddr, hburst, hsize);
  assign load_addr = req_addr & ~((AW'(1) << req_size) - AW'(1));

  always_comb begin
    if (req_burst == 3'b000)      load_rem = '0;
    else if (req_burst == 3'b001) load_rem = CW'(req_len);
    else                          load_rem = CW'((5'd2 << req_burst[2:1]) - 5'd1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      haddr  <= '0;
      htrans <= T_IDLE;
      hburst <= 3'b000;
      hsize  <= 3'b000;
      hwrite <= 1'b0;
      rem    <= '0;
    end else if (hready) begin
      if (rem != '0) begin
        haddr <= adv_addr;
        if (req_pause) begin
          htrans <= T_BUSY;
        end else begin
          htrans <= T_SEQ;
          rem    <= rem - CW'(1);
        end
      end else if (addr_req && req_valid) begin
        haddr  <= load_addr;
        htrans <= T_NSEQ;
        hburst <= req_burst;
        hsize  <= req_size;
        hwrite <= req_write;
        rem    <= load_rem;
      end else begin
        htrans <= T_IDLE;
      end
    end
  end
endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          hready,
  input logic          hgrant,
  input logic          req_valid,
  input logic [2:0]    req_burst,
  input logic [AW-1:0] haddr,
  input logic [1:0]    htrans,
  input logic [2:0]    hburst,
  input logic [2:0]    hsize,
  input logic          hwrite,
  input logic          addr_req
);
  // R7
  hold_on_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hready |=> $stable(haddr) && $stable(htrans) && $stable(hburst) && $stable(hsize) && $stable(hwrite));
  // R2
  accept_nonseq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_req && req_valid) |=> (htrans == 2'b10) && (hburst == $past(req_burst)));
  // R10
  idle_no_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_req && !req_valid) |=> (htrans == 2'b00));
  // R3
  seq_follows_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (htrans == 2'b11) |-> ($past(htrans) != 2'b00));
  // R6
  busy_resumes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hready && htrans == 2'b01) |=> (htrans == 2'b01 || htrans == 2'b11));
endmodule

bind burst_addr_seq burst_addr_seq_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .hready(hready), .hgrant(hgrant), .req_valid(req_valid),
  .req_burst(req_burst), .haddr(haddr), .htrans(htrans), .hburst(hburst), .hsize(hsize),
  .hwrite(hwrite), .addr_req(addr_req)
);

// File: tb/burst_addr_seq_tb.sv
module burst_addr_seq_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic hgrant = 0, hready = 0, req_valid = 0, req_write = 0, req_pause = 0;
  logic [31:0] req_addr = '0;
  logic [2:0] req_burst = '0, req_size = '0;
  logic [7:0] req_len = '0;
  logic [31:0] haddr;
  logic [1:0] htrans;
  logic [2:0] hburst, hsize;
  logic hwrite, addr_req, wdata_req;
  int total = 0, bad = 0;
  bit finished = 0;

  logic [31:0] q[$];
  logic [31:0] m_addr = '0;
  logic [1:0] m_trans = 2'b00;
  logic [2:0] m_burst = '0, m_size = '0;
  logic m_write = 0, prev_ready = 1, prev_pause = 0, prev_idle_req = 0;

  always #2.5 clk = ~clk;

  burst_addr_seq u_dut (.clk(clk), .rst_n(rst_n), .hgrant(hgrant), .hready(hready),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr), .req_burst(req_burst),
    .req_size(req_size), .req_len(req_len), .req_pause(req_pause), .haddr(haddr),
    .htrans(htrans), .hburst(hburst), .hsize(hsize), .hwrite(hwrite),
    .addr_req(addr_req), .wdata_req(wdata_req));

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc(input bit g, r, v, w, input logic [31:0] a, input logic [2:0] b, s,
                     input logic [7:0] l, input bit p);
    int n, bytes, span;
    logic [31:0] al, base;
    bit wrap;
    @(negedge clk);
    hgrant = g; hready = r; req_valid = v; req_write = w; req_addr = a;
    req_burst = b; req_size = s; req_len = l; req_pause = p;
    #1;
    if (!prev_ready) chk({30'd0, htrans}, {30'd0, m_trans}, "R7 htrans");
    else if (prev_pause && m_trans == 2'b01) chk({30'd0, htrans}, {30'd0, m_trans}, "R6 htrans");
    else if (prev_idle_req) chk({30'd0, htrans}, {30'd0, m_trans}, "R10 htrans");
    else chk({30'd0, htrans}, {30'd0, m_trans}, "R3 htrans");
    if (m_trans == 2'b10) chk(haddr, m_addr, "R9 haddr");
    else if (m_burst != 3'b000 && !m_burst[0]) chk(haddr, m_addr, "R5 haddr");
    else chk(haddr, m_addr, "R4 haddr");
    chk({29'd0, hburst}, {29'd0, m_burst}, "R2 hburst");
    chk({29'd0, hsize}, {29'd0, m_size}, "R2 hsize");
    chk({31'd0, hwrite}, {31'd0, m_write}, "R2 hwrite");
    chk({31'd0, addr_req}, {31'd0, r && g && q.size() == 0}, "R2 addr_req");
    chk({31'd0, wdata_req}, {31'd0, r && m_write && m_trans[1]}, "R8 wdata_req");
    prev_ready = r;
    prev_pause = p && q.size() != 0;
    prev_idle_req = r && q.size() == 0 && !(g && v);
    if (r) begin
      if (q.size() != 0) begin
        if (p) begin m_trans = 2'b01; m_addr = q[0]; end
        else begin m_trans = 2'b11; m_addr = q.pop_front(); end
      end else if (g && v) begin
        bytes = 1 << s;
        al = a & ~(32'(bytes) - 1);
        n = (b == 3'b000) ? 1 : (b == 3'b001) ? int'(l) + 1 : (2 << b[2:1]);
        wrap = (b != 3'b000) && !b[0];
        span = n * bytes;
        base = al - (al % span);
        for (int i = 0; i < n; i++)
          q.push_back(wrap ? base + ((al % span) + i * bytes) % span : al + i * bytes);
        m_trans = 2'b10; m_burst = b; m_size = s; m_write = w; m_addr = q.pop_front();
      end else m_trans = 2'b00;
    end
  endtask

  initial begin
    #(5.0 * 200000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk({30'd0, htrans}, 32'd0, "R1 htrans");
    chk(haddr, 32'd0, "R1 haddr");
    chk({25'd0, hburst, hsize, hwrite}, 32'd0, "R1 control");

    // R5 WRAP4 word from 0x38: 38,3C,30,34
    cyc(1,1,1,1,32'h38,3'b010,3'd2,8'd0,0);
    cyc(1,1,0,0,0,0,0,0,0); chk(haddr, 32'h38, "R5 wrap beat0");
    cyc(1,1,0,0,0,0,0,0,0); chk(haddr, 32'h3C, "R5 wrap beat1");
    cyc(1,1,0,0,0,0,0,0,0); chk(haddr, 32'h30, "R5 wrap beat2");
    chk({30'd0, htrans}, 32'd3, "R3 seq after wrap");
    cyc(1,1,0,0,0,0,0,0,0); chk(haddr, 32'h34, "R5 wrap beat3");
    // R10 granted without request
    cyc(1,1,0,0,0,0,0,0,0); chk({30'd0, htrans}, 32'd0, "R10 idle");
    // R11 pause while idle has no effect
    cyc(1,1,0,0,0,0,0,0,1); chk({30'd0, htrans}, 32'd0, "R11 idle pause");
    // R9 misaligned halfword INCR4 at 0x103, pause on beat 2, wait during BUSY
    cyc(1,1,1,0,32'h103,3'b011,3'd1,8'd0,1);
    cyc(1,1,0,0,0,0,0,0,0); chk(haddr, 32'h102, "R9 aligned start");
    cyc(1,1,0,0,0,0,0,0,1); chk(haddr, 32'h104, "R4 incr");
    cyc(1,0,0,0,0,0,0,0,0); chk({30'd0, htrans}, 32'd1, "R6 busy");
    chk(haddr, 32'h106, "R6 busy addr");
    cyc(1,1,0,0,0,0,0,0,0); chk({30'd0, htrans}, 32'd1, "R7 held busy");
    cyc(1,1,0,0,0,0,0,0,0); chk(haddr, 32'h106, "R6 resume addr");
    chk({30'd0, htrans}, 32'd3, "R6 resume seq");
    // R3 INCR with req_len 2 gives 3 beats
    cyc(1,1,0,0,0,0,0,0,0);
    cyc(1,1,1,1,32'h200,3'b001,3'd2,8'd2,0);
    repeat (3) cyc(1,1,0,0,0,0,0,0,0);
    cyc(1,1,0,0,0,0,0,0,0); chk({30'd0, htrans}, 32'd0, "R3 incr length");

    for (int k = 0; k < 4000; k++)
      cyc($urandom_range(0,9) < 8, $urandom_range(0,3) != 0, $urandom_range(0,1),
          $urandom_range(0,1), {16'd0, 16'($urandom)}, 3'($urandom_range(0,7)),
          3'($urandom_range(0,2)), 8'($urandom_range(0,6)), $urandom_range(0,4) == 0);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule